// File: doc/BRIEF.md
# Return Address Stack with Near-Full Interrupt

This block is a last-in, first-out store for return addresses. A program sequencer pushes the return point when it enters a subroutine, takes an interrupt or starts a hardware loop, and pops it again on the matching return or loop exit. The number of occupied entries is always visible on the stack pointer output.

The block keeps four sticky status bits: stack became full, stack became empty, push lost to overflow, and pop made on an empty stack. These bits stay set until a clear strobe arrives. An interrupt request output rises, unless it is masked, once the stack holds one entry less than its capacity. The handler's own push then fills the stack, and that sets the sticky full bit, which keeps the request up. Software can therefore unload or report the stack before any address is lost.

Top module: `ret_stack`

## Requirements
- R1: After a synchronous active-low reset, the pointer reads 0, the pop data reads 0, the status reads 4'b0001 (only the empty bit is set) and the interrupt request is low.
- R2: The pointer equals the number of occupied entries. It ranges from 0 to DEPTH (30 by default) and never goes beyond DEPTH.
- R3: A pop returns the most recently pushed value that has not yet been popped. The value appears on the pop data output in the cycle after the pop strobe and is held until the next pop.
- R4: A push alone on a stack that is not full stores the data and raises the pointer by one. A pop alone on a stack that is not empty lowers the pointer by one.
- R5: When push and pop arrive together on a non-empty stack, the old top goes to the pop data output, the push data replaces the top, and the pointer is unchanged. When they arrive together on an empty stack, the pop data is 0, the underflow bit is set, the push data is stored and the pointer becomes 1.
- R6: A push alone on a full stack is dropped. The pointer stays at DEPTH, the stored entries are unchanged, and status bit 2 (overflow) is set.
- R7: A pop alone on an empty stack returns 0 on the pop data output, leaves the pointer at 0, and sets status bit 3 (underflow).
- R8: Status bit 1 (full) is set when a push raises the pointer to DEPTH. Status bit 0 (empty) is set when a pop lowers the pointer to 0, and it is also set by reset.
- R9: The interrupt request equals (not mask) AND (pointer >= DEPTH-1 OR full bit set). While the mask input is high, the request is low.
- R10: A clear strobe makes all four status bits 0 in the next cycle, and it wins over any set event in the same cycle. Without a clear, the status bits hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| push_data_i | input | WIDTH | Address to push |
| clr_i | input | 1 | Clears all sticky status bits |
| irq_mask_i | input | 1 | High blocks the interrupt request |
| pop_data_o | output | WIDTH | Value taken by the last pop |
| sp_o | output | $clog2(DEPTH+1) | Number of occupied entries |
| status_o | output | 4 | {underflow, overflow, full, empty} sticky bits |
| irq_o | output | 1 | Near-full / full interrupt request |

## Verification
The bench builds the block with its default values, DEPTH of 30 and WIDTH of 24. With these values it can reach the real boundary levels: the near-full request at 29 entries, the fill at 30 entries, and the dropped push beyond 30. It also drives the block back down through the level where the request drops, and on to an empty stack. The short vector table covers mixed push, pop and swap patterns at low fill. The directed part covers the mask, the clear priority and underflow with a simultaneous push.

// File: rtl/ret_stack_pkg.sv
// Shared definitions for the return stack: status bit positions and operation codes.
package ret_stack_pkg;
    localparam int ST_EMPTY = 0;
    localparam int ST_FULL  = 1;
    localparam int ST_OVF   = 2;
    localparam int ST_UDF   = 3;
    localparam int ST_BITS  = 4;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } stk_op_e;
endpackage

// File: rtl/rs_level_ctrl.sv
// Occupancy counter and operation decoder.
// Turns the push and pop strobes into memory write and read requests and
// status events. Assumes the strobes are single-cycle and already synchronous.
module rs_level_ctrl
    import ret_stack_pkg::*;
#(
    parameter int DEPTH = 30,
    parameter int LW    = $clog2(DEPTH + 1),
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [LW-1:0] level,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          rd_zero,
    output logic          ev_full,
    output logic          ev_empty,
    output logic          ev_ovf,
    output logic          ev_udf
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [LW-1:0] NEAR_LVL = LW'(DEPTH - 1);
    localparam logic [LW-1:0] ONE_LVL  = LW'(1);

    stk_op_e       op;
    logic [LW-1:0] level_nx;
    logic          is_full, is_empty;

    assign op       = stk_op_e'({pop, push});
    assign is_full  = (level == FULL_LVL);
    assign is_empty = (level == '0);

    // Decode the operation into the next level, the memory requests and the events.
    always_comb begin
        level_nx = level;
        wr_en    = 1'b0;
        wr_addr  = '0;
        rd_en    = 1'b0;
        rd_addr  = '0;
        rd_zero  = 1'b0;
        ev_full  = 1'b0;
        ev_empty = 1'b0;
        ev_ovf   = 1'b0;
        ev_udf   = 1'b0;
        unique case (op)
            OP_PUSH: begin
                if (is_full) begin
                    ev_ovf = 1'b1;
                end else begin
                    wr_en    = 1'b1;
                    wr_addr  = AW'(level);
                    level_nx = level + ONE_LVL;
                    ev_full  = (level == NEAR_LVL);
                end
            end
            OP_POP: begin
                if (is_empty) begin
                    ev_udf  = 1'b1;
                    rd_zero = 1'b1;
                end else begin
                    rd_en    = 1'b1;
                    rd_addr  = AW'(level - ONE_LVL);
                    level_nx = level - ONE_LVL;
                    ev_empty = (level == ONE_LVL);
                end
            end
            OP_SWAP: begin
                if (is_empty) begin
                    ev_udf   = 1'b1;
                    rd_zero  = 1'b1;
                    wr_en    = 1'b1;
                    wr_addr  = '0;
                    level_nx = ONE_LVL;
                end else begin
                    rd_en   = 1'b1;
                    rd_addr = AW'(level - ONE_LVL);
                    wr_en   = 1'b1;
                    wr_addr = AW'(level - ONE_LVL);
                end
            end
            default: ;
        endcase
    end

    // Register the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) level <= '0;
        else        level <= level_nx;
    end

    // R2: the occupancy never goes beyond the capacity
    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);

    // R4: a lone push on a non-full stack raises the level by one
    a_r4_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level != FULL_LVL) |=> (level == $past(level) + ONE_LVL));

    // R5: a swap on a non-empty stack keeps the level
    a_r5_swap_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && level != '0) |=> $stable(level));

    // R6: a push on a full stack leaves it full
    a_r6_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level == FULL_LVL) |=> (level == FULL_LVL));
endmodule

// File: rtl/rs_store.sv
// Entry storage and pop-data register.
// Writes one entry per cycle. A read captures the addressed entry, or zero
// on underflow, into the output register. Reads see the value from before
// any write made in the same cycle.
module rs_store #(
    parameter int DEPTH = 30,
    parameter int WIDTH = 24,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    input  logic             rd_zero,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Write the addressed entry.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Capture the popped value, or zero on underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data <= '0;
        else if (rd_en)   rd_data <= mem[rd_addr];
        else if (rd_zero) rd_data <= '0;
    end

    // R7: an underflowing pop yields zero
    a_r7_udf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_zero |=> (rd_data == '0));

    // R3: without a read request the output holds its value
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !rd_zero) |=> $stable(rd_data));
endmodule

// File: rtl/rs_status.sv
// Sticky status bits and interrupt request.
// Sets bits from single-cycle events and clears all of them on a clear
// strobe, which wins over any set in the same cycle. The request is formed
// from the level and the full bit, gated by the mask.
module rs_status
    import ret_stack_pkg::*;
#(
    parameter int DEPTH = 30,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LW-1:0]      level,
    input  logic               ev_full,
    input  logic               ev_empty,
    input  logic               ev_ovf,
    input  logic               ev_udf,
    input  logic               clr,
    input  logic               irq_mask,
    output logic [ST_BITS-1:0] sticky,
    output logic               irq
);
    localparam logic [LW-1:0] NEAR_LVL = LW'(DEPTH - 1);

    logic [ST_BITS-1:0] ev_vec;

    // Gather the events into status bit positions.
    always_comb begin
        ev_vec           = '0;
        ev_vec[ST_EMPTY] = ev_empty;
        ev_vec[ST_FULL]  = ev_full;
        ev_vec[ST_OVF]   = ev_ovf;
        ev_vec[ST_UDF]   = ev_udf;
    end

    // Hold the sticky bits: reset marks empty, clear wins over sets.
    always_ff @(posedge clk) begin
        if (!rst_n)   sticky <= ST_BITS'(1) << ST_EMPTY;
        else if (clr) sticky <= '0;
        else          sticky <= sticky | ev_vec;
    end

    // Raise the request near or at capacity unless masked.
    assign irq = !irq_mask && ((level >= NEAR_LVL) || sticky[ST_FULL]);

    // R10: a clear empties the status register
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sticky == '0));

    // R6: an overflow event is recorded when not cleared
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ovf && !clr) |=> sticky[ST_OVF]);

    // R9: the mask suppresses the request
    a_r9_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq);

    // R10: without a clear no bit falls
    a_r10_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((sticky & $past(sticky)) == $past(sticky)));
endmodule

// File: rtl/ret_stack.sv
// Return address stack, top level.
// Joins the level controller, entry storage and status logic. Assumes
// single-cycle strobes from a synchronous sequencer.
module ret_stack
    import ret_stack_pkg::*;
#(
    parameter int DEPTH = 30,
    parameter int WIDTH = 24,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             clr_i,
    input  logic             irq_mask_i,
    output logic [WIDTH-1:0] pop_data_o,
    output logic [LW-1:0]    sp_o,
    output logic [3:0]       status_o,
    output logic             irq_o
);
    localparam int AW = $clog2(DEPTH);

    logic          wr_en, rd_en, rd_zero;
    logic [AW-1:0] wr_addr, rd_addr;
    logic          ev_full, ev_empty, ev_ovf, ev_udf;
    logic [LW-1:0] level;

    rs_level_ctrl #(.DEPTH(DEPTH), .LW(LW), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push(push_i), .pop(pop_i),
        .level(level), .wr_en(wr_en), .wr_addr(wr_addr),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_zero(rd_zero),
        .ev_full(ev_full), .ev_empty(ev_empty), .ev_ovf(ev_ovf), .ev_udf(ev_udf)
    );

    rs_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(push_data_i), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_zero(rd_zero), .rd_data(pop_data_o)
    );

    rs_status #(.DEPTH(DEPTH), .LW(LW)) u_status (
        .clk(clk), .rst_n(rst_n), .level(level),
        .ev_full(ev_full), .ev_empty(ev_empty), .ev_ovf(ev_ovf), .ev_udf(ev_udf),
        .clr(clr_i), .irq_mask(irq_mask_i), .sticky(status_o), .irq(irq_o)
    );

    assign sp_o = level;
endmodule

// File: tb/ret_stack_bench.sv
// Bench for the return stack: a vector table walk, then directed corner cases.
module ret_stack_bench;
    localparam int DEPTH = 30;
    localparam int WIDTH = 24;
    localparam int LW    = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push = 1'b0, pop = 1'b0, clr = 1'b0, mask = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] dout;
    logic [LW-1:0]    sp;
    logic [3:0]       st;
    logic             irq;
    int               n_run = 0;
    int               n_fail = 0;

    always #2 clk = ~clk;

    ret_stack u_ret_stack (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
        .push_data_i(din), .clr_i(clr), .irq_mask_i(mask),
        .pop_data_o(dout), .sp_o(sp), .status_o(st), .irq_o(irq)
    );

    // Vector layout: {push, pop, data[23:0], exp_sp[4:0], exp_pop[23:0]}
    localparam logic [54:0] VEC [8] = '{
        {1'b1, 1'b0, 24'h0000A1, 5'd1, 24'h000000},
        {1'b1, 1'b0, 24'h0000B2, 5'd2, 24'h000000},
        {1'b0, 1'b1, 24'h000000, 5'd1, 24'h0000B2},
        {1'b1, 1'b1, 24'h0000C3, 5'd1, 24'h0000A1},
        {1'b0, 1'b1, 24'h000000, 5'd0, 24'h0000C3},
        {1'b0, 1'b1, 24'h000000, 5'd0, 24'h000000},
        {1'b1, 1'b0, 24'h0000D4, 5'd1, 24'h000000},
        {1'b0, 1'b1, 24'h000000, 5'd0, 24'h0000D4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic pu, input logic po, input logic cl, input logic [WIDTH-1:0] d);
        @(negedge clk);
        push = pu; pop = po; clr = cl; din = d;
        @(posedge clk);
        #1;
        push = 1'b0; pop = 1'b0; clr = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 sp", 32'(sp), 0);
        chk("R1 pop_data", 32'(dout), 0);
        chk("R1 status", 32'(st), 32'h1);
        chk("R1 irq", 32'(irq), 0);

        // R3 R4 R5 R7: table walk
        foreach (VEC[i]) begin
            step(VEC[i][54], VEC[i][53], 1'b0, VEC[i][52:29]);
            chk("R4 table sp", 32'(sp), 32'(VEC[i][28:24]));
            chk("R3 table pop_data", 32'(dout), 32'(VEC[i][23:0]));
        end
        chk("R7 R8 status after table", 32'(st), 32'h9);

        step(1'b0, 1'b0, 1'b1, '0);
        chk("R10 clear", 32'(st), 0);
        step(1'b0, 1'b0, 1'b0, '0);
        chk("R10 hold empty stays clear", 32'(st), 0);

        // R5: swap on an empty stack
        step(1'b1, 1'b1, 1'b0, 24'h000ABC);
        chk("R5 empty swap pop_data", 32'(dout), 0);
        chk("R5 empty swap sp", 32'(sp), 1);
        chk("R5 empty swap underflow", 32'(st), 32'h8);
        step(1'b0, 1'b1, 1'b1, '0);
        chk("R5 empty swap stored", 32'(dout), 32'h000ABC);
        chk("R10 clear wins over empty set", 32'(st), 0);

        // R9: fill toward capacity
        for (int k = 0; k < 28; k++) step(1'b1, 1'b0, 1'b0, 24'(32'h100 + k));
        chk("R2 sp at 28", 32'(sp), 28);
        chk("R9 no irq at 28", 32'(irq), 0);
        step(1'b1, 1'b0, 1'b0, 24'h00011C);
        chk("R9 irq at 29", 32'(irq), 1);
        chk("R8 full not yet", 32'(st), 0);
        @(negedge clk);
        mask = 1'b1;
        #1;
        chk("R9 masked", 32'(irq), 0);
        @(negedge clk);
        mask = 1'b0;
        step(1'b1, 1'b0, 1'b0, 24'h00011D);
        chk("R2 sp full", 32'(sp), 30);
        chk("R8 full set", 32'(st), 32'h2);
        step(1'b1, 1'b0, 1'b0, 24'hFFFFFF);
        chk("R6 sp stays", 32'(sp), 30);
        chk("R6 overflow set", 32'(st), 32'h6);
        step(1'b0, 1'b1, 1'b0, '0);
        chk("R6 top unchanged", 32'(dout), 32'h00011D);
        chk("R4 pop step", 32'(sp), 29);
        step(1'b0, 1'b0, 1'b1, '0);
        chk("R9 irq by level", 32'(irq), 1);
        step(1'b0, 1'b1, 1'b0, '0);
        chk("R3 pop 28", 32'(dout), 32'h00011C);
        chk("R9 irq drops", 32'(irq), 0);

        // R10: drain, clearing in the cycle the stack empties
        for (int k = 0; k < 27; k++) step(1'b0, 1'b1, 1'b0, '0);
        step(1'b0, 1'b1, 1'b1, '0);
        chk("R3 bottom entry", 32'(dout), 32'h000100);
        chk("R10 clear beats empty", 32'(st), 0);
        step(1'b0, 1'b1, 1'b0, '0);
        chk("R7 underflow only", 32'(st), 32'h8);
        chk("R7 sp zero", 32'(sp), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule